// File: doc/BRIEF.md
# CSR Privilege and Trap-Return Legality Guard

This block sits beside the instruction decoder of a RISC-V style core. Each cycle it looks at the decoded strobes and decides whether the instruction can go ahead. A strobe is either a CSR access, with its 12-bit address and a write flag, or one of the two trap-return instructions. The minimum privilege a CSR needs is taken from address bits [9:8]. Writes into the read-only quarter of the CSR space are refused. Machine-return and supervisor-return are checked against the current privilege, each with its own rule.

An illegal instruction produces an illegal-instruction trap request in the same cycle it is presented, with cause code 2. The request comes with the privilege the hart was running at, which is the value for the previous-privilege field. Legal accesses get a grant and, for writes, a write enable. These are withheld whenever the trap fires, so no CSR state can change in that cycle. A register keeps the previous privilege captured at the most recent trap.

Top module: `csr_priv_guard`

## Requirements
- R1: The required level is CSR address bits [9:8]: 00 is user, 01 is supervisor, 11 is machine, and the reserved value 10 counts as machine. An access with `cur_priv` (00 U, 01 S, 11 M) numerically at or above that level asserts `csr_grant` in the same cycle.
- R2: A CSR access whose `cur_priv` is numerically below the required level asserts `trap_req` in the same cycle. Supervisor access to any machine-level CSR therefore traps.
- R3: A write (`csr_write`=1) to an address with bits [11:10] equal to 11 traps even when the privilege test passes. A read of that space is granted under R1.
- R4: `mret_valid` yields `mret_go` only when `cur_priv` is 11. At any other level it yields `trap_req` instead.
- R5: `sret_valid` yields `sret_go` when `cur_priv` is 11 or 01. At 00 it yields `trap_req`.
- R6: `trap_cause` is 2 while `trap_req` is high and 0 otherwise.
- R7: While `trap_req` is high, `trap_prev_priv` equals `cur_priv`. On the following clock edge `saved_prev_priv` takes that value, and it holds between traps.
- R8: In a trap cycle `csr_grant`, `csr_we`, `mret_go` and `sret_go` are all low. With no strobe, every output except `saved_prev_priv` is low.
- R9: After reset, `saved_prev_priv` is 11 (machine).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_priv | input | 2 | Current privilege (00 U, 01 S, 11 M) |
| csr_valid | input | 1 | Decoded CSR access strobe |
| csr_addr | input | 12 | CSR address |
| csr_write | input | 1 | Access modifies the CSR |
| mret_valid | input | 1 | Decoded machine-return strobe |
| sret_valid | input | 1 | Decoded supervisor-return strobe |
| trap_req | output | 1 | Illegal-instruction trap request |
| trap_cause | output | CAUSE_W | Cause code, 2 during a trap |
| trap_prev_priv | output | 2 | Privilege to record as previous privilege |
| csr_grant | output | 1 | Access is legal |
| csr_we | output | 1 | Legal write enable for CSR storage |
| mret_go | output | 1 | Machine-return may proceed |
| sret_go | output | 1 | Supervisor-return may proceed |
| saved_prev_priv | output | 2 | Previous privilege captured at the latest trap |

## Verification
The assertions assume that the decoder raises at most one of the three strobes per cycle, that `cur_priv` never holds the reserved value 10, and that the address is known whenever an access is strobed. The sweep issues one strobe per cycle and visits only the three defined privilege levels. It covers every value of address bits [11:8] in both directions, and each return instruction at each level, with idle cycles between them. These idle cycles check that `saved_prev_priv` holds its value.

// File: rtl/csr_priv_guard.sv
module csr_priv_guard #(
  parameter int CAUSE_W = 32,
  parameter int ILLEGAL_CODE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cur_priv,
  input  logic               csr_valid,
  input  logic [11:0]        csr_addr,
  input  logic               csr_write,
  input  logic               mret_valid,
  input  logic               sret_valid,
  output logic               trap_req,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic [1:0]         trap_prev_priv,
  output logic               csr_grant,
  output logic               csr_we,
  output logic               mret_go,
  output logic               sret_go,
  output logic [1:0]         saved_prev_priv
);
  localparam logic [1:0] LVL_U = 2'b00;
  localparam logic [1:0] LVL_M = 2'b11;
  localparam logic [CAUSE_W-1:0] CAUSE_ILL = CAUSE_W'(ILLEGAL_CODE);

  logic [1:0] need_lvl;
  logic priv_ok, ro_hit, csr_bad, mret_bad, sret_bad;

  assign need_lvl = (csr_addr[9:8] == 2'b10) ? LVL_M : csr_addr[9:8];
  assign priv_ok  = cur_priv >= need_lvl;
  assign ro_hit   = csr_write && (csr_addr[11:10] == 2'b11);
  assign csr_bad  = csr_valid && (!priv_ok || ro_hit);
  assign mret_bad = mret_valid && (cur_priv != LVL_M);
  assign sret_bad = sret_valid && (cur_priv == LVL_U);

  assign trap_req       = csr_bad || mret_bad || sret_bad;
  assign trap_cause     = trap_req ? CAUSE_ILL : '0;
  assign trap_prev_priv = trap_req ? cur_priv : LVL_U;
  assign csr_grant      = csr_valid && !csr_bad;
  assign csr_we         = csr_grant && csr_write;
  assign mret_go        = mret_valid && !mret_bad;
  assign sret_go        = sret_valid && !sret_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        saved_prev_priv <= LVL_M;
    else if (trap_req) saved_prev_priv <= cur_priv;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({csr_valid, mret_valid, sret_valid})) else $error("strobes"); // R8
  AST_ADDR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    csr_valid |-> !$isunknown(csr_addr)) else $error("addr x"); // R1
  AST_NO_COMMIT_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> !(csr_we || mret_go || sret_go)) else $error("commit on trap"); // R8
  AST_PREV_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> saved_prev_priv == $past(cur_priv)) else $error("prev capture"); // R7
  AST_PREV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |=> $stable(saved_prev_priv)) else $error("prev hold"); // R7
  AST_MRET_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    mret_go |-> cur_priv == LVL_M) else $error("mret level"); // R4
  AST_SRET_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    sret_go |-> cur_priv != LVL_U) else $error("sret level"); // R5
  AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |-> csr_addr[11:10] != 2'b11) else $error("ro write"); // R3
  AST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> trap_cause == CAUSE_W'(2)) else $error("cause"); // R6
endmodule

// File: tb/csr_priv_guard_test.sv
module csr_priv_guard_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] cur_priv = 0;
  logic csr_valid = 0, csr_write = 0, mret_valid = 0, sret_valid = 0;
  logic [11:0] csr_addr = 0;
  logic trap_req, csr_grant, csr_we, mret_go, sret_go;
  logic [31:0] trap_cause;
  logic [1:0] trap_prev_priv, saved_prev_priv;
  int errors = 0, checks = 0;
  logic [1:0] exp_saved = 2'b11;

  always #10 clk = ~clk;

  csr_priv_guard uut (.*);

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic settle_and_check(input logic trap, input logic [1:0] p);
    #1;
    chk("R6 cause", trap_cause, trap ? 64'd2 : 64'd0);
    if (trap) chk("R7 prev", trap_prev_priv, p);
    if (trap) chk("R8 no commit", {csr_grant, csr_we, mret_go, sret_go}, 0);
    @(posedge clk);
    if (trap) exp_saved = p;
    @(negedge clk);
    csr_valid = 0; mret_valid = 0; sret_valid = 0; csr_write = 0;
    #1;
    chk("R8 idle", {trap_req, csr_grant, csr_we, mret_go, sret_go}, 0);
    chk("R7 saved", saved_prev_priv, exp_saved);
    @(negedge clk);
    chk("R7 hold", saved_prev_priv, exp_saved);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #35;
    chk("R9 reset", saved_prev_priv, 2'b11);
    rst_n = 1;
    @(negedge clk);
    chk("R9 after reset", saved_prev_priv, 2'b11);
    for (int pi = 0; pi < 3; pi++) begin
      logic [1:0] p;
      p = (pi == 2) ? 2'b11 : 2'(pi);
      for (int hi = 0; hi < 16; hi++) begin
        for (int w = 0; w < 2; w++) begin
          logic [1:0] req;
          logic ok;
          cur_priv = p;
          csr_addr = {4'(hi), 8'(hi * 37 + 5)};
          csr_write = 1'(w);
          csr_valid = 1;
          req = (hi[1:0] == 2'b10) ? 2'b11 : hi[1:0];
          ok = (p >= req) && !(w == 1 && hi[3:2] == 2'b11);
          #1;
          if (p < req) chk("R2 priv trap", trap_req, 1);
          else if (w == 1 && hi[3:2] == 2'b11) chk("R3 ro write trap", trap_req, 1);
          else chk("R1 grant", {csr_grant, trap_req}, 2'b10);
          chk("R3 we", csr_we, ok && w == 1);
          settle_and_check(!ok, p);
        end
      end
      cur_priv = p; mret_valid = 1;
      #1;
      chk("R4 mret", {mret_go, trap_req}, (p == 2'b11) ? 2'b10 : 2'b01);
      settle_and_check(p != 2'b11, p);
      cur_priv = p; sret_valid = 1;
      #1;
      chk("R5 sret", {sret_go, trap_req}, (p != 2'b00) ? 2'b10 : 2'b01);
      settle_and_check(p == 2'b00, p);
    end
    cur_priv = 2'b01; csr_addr = 12'h340; csr_valid = 1; csr_write = 0;
    #1; chk("R2 S reads M csr", trap_req, 1);
    settle_and_check(1, 2'b01);
    cur_priv = 2'b01; csr_addr = 12'h140; csr_valid = 1; csr_write = 1;
    #1; chk("R1 S writes S scratch", {csr_grant, csr_we, trap_req}, 3'b110);
    settle_and_check(0, 2'b01);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule